// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 36-bit words between a producer on one free-running clock and a consumer on another. The two clocks may be unrelated or the same, and a write and a read may land on the same edge. The storage depth is a parameter (256, 512 or 1024 words). Pointers cross between the clock domains as Gray code through two-flop synchronizers. The full indication is computed on the write clock and the empty indication on the read clock.

Two flag styles can be chosen, and the choice is sampled during master reset. In standard style the status pins mean "full" and "empty", and a read request places the next word on the output after the following read-clock edge. In fall-through style the pins mean "space available" and "word available", and the oldest word appears at the output without a request. Two threshold flags warn of a nearly empty or nearly full store. Their offsets come from one of three defaults picked at master reset, or they are programmed after it, either as two parallel writes or as a serial bit stream. A partial reset empties the store and keeps the style and offsets.

Top module: `fifo_dc_flags`

## Requirements
- R1: Master reset is synchronous and active low (`mrst_n`, held for at least four cycles of the slower clock). After it, in standard style, `rd_stat`=1, `wr_stat`=0, `almost_empty`=1 and `almost_full`=0. In fall-through style `rd_stat`=0 and `wr_stat`=1.
- R2: Words leave in the order they were accepted, whatever the clock ratio and however the enables are timed.
- R3: In standard style (`fwft_sel`=0 at master reset), `rd_stat`=1 means empty. A cycle with `rd_en`=1 and `rd_stat`=0 puts the next word on `dout` at that read-clock edge. `wr_stat` becomes 1 once DEPTH words are held.
- R4: A write while the store is full and a read while it is empty are ignored. The stored contents and `dout` are unchanged.
- R5: In fall-through style (`fwft_sel`=1 at master reset), the oldest word is driven on `dout` with `rd_stat`=1 without any request. A cycle with `rd_en`=1 consumes it, and `wr_stat`=1 means space is available.
- R6: `almost_empty` is 1 when the number of words in storage not yet moved to the output is at most the empty offset. `almost_full` is 1 when the free space is at most the full offset. With `ofs_sel` = 00, 01 or 10 at master reset, both offsets are 8, 16 or 64 respectively.
- R7: With `ofs_sel`=11 and `ser_mode`=0 at master reset, the first two accepted writes load the empty offset and then the full offset from `din[AW-1:0]`. These writes store no data.
- R8: With `ofs_sel`=11 and `ser_mode`=1, 2·AW bits on `ser_din` are taken on write-clock edges where `ser_en`=1, most significant bit first, empty offset first. Writes made before the last bit are ignored.
- R9: Partial reset (`prst_n` low) empties the store and keeps the flag style and both offsets.
- R10: `fwft_sel`, `ofs_sel` and `ser_mode` have effect only while master reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks |
| fwft_sel | input | 1 | Flag style at master reset: 0 standard, 1 fall-through |
| ofs_sel | input | 2 | Offset choice at master reset: 00=8, 01=16, 10=64, 11=program |
| ser_mode | input | 1 | Programming method: 0 parallel, 1 serial |
| ser_en | input | 1 | Serial programming bit strobe (write clock) |
| ser_din | input | 1 | Serial programming bit |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data, or an offset value during parallel programming |
| wr_stat | output | 1 | Full (standard) or space available (fall-through) |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_en | input | 1 | Read request |
| dout | output | DW | Read data |
| rd_stat | output | 1 | Empty (standard) or word available (fall-through) |
| almost_empty | output | 1 | Stored words at or below the empty offset |

## Verification
A pointer that skips or repeats an entry shows at `dout` as a word out of order or a repeated word on the very next read of that entry. A threshold flag that is off by one shows within a few cycles of the slower clock once writes stop at the boundary level. A corrupted offset register shows as a threshold flag that trips at the default level instead of the programmed one. A style latch that moves after reset inverts the sense of the status pins at once. The random run, with a 2:3 clock ratio, compares each word against a queue as it leaves.

// File: rtl/fifo_dc_pkg.sv
// Package: shared offset-selection type and default offset lookup.
// Assumes offsets fit the pointer address width of the instantiating FIFO.
package fifo_dc_pkg;

    typedef enum logic [1:0] {
        OFS_8    = 2'b00,
        OFS_16   = 2'b01,
        OFS_64   = 2'b10,
        OFS_PROG = 2'b11
    } ofs_sel_e;

    // Default threshold for a given selection; programming mode starts at 8.
    function automatic int unsigned default_offset(input ofs_sel_e s);
        int unsigned v;
        case (s)
            OFS_16:  v = 16;
            OFS_64:  v = 64;
            default: v = 8;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fifo_dc_sync2.sv
// Two-flop synchronizer for a multi-bit Gray-coded pointer.
// Assumes the input changes at most one bit per source clock.
module fifo_dc_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture then re-time the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_dc_cfg.sv
// Configuration: latches flag style and offsets at master reset and runs
// parallel or serial offset programming on the write clock.
// Assumes prst_n is high while programming; partial reset never alters state.
module fifo_dc_cfg
    import fifo_dc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic [1:0]    ofs_sel,
    input  logic          ser_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] prog_val,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic          fwft,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic          cfg_done
);
    localparam int PBITS = 2 * AW;
    localparam int CW    = $clog2(PBITS + 1);

    logic          prog;
    logic          serial;
    logic [CW-1:0] pcnt;
    logic [CW-1:0] target;

    assign target   = serial ? CW'(PBITS) : CW'(2);
    assign cfg_done = !prog || (pcnt == target);

    // Latch configuration at master reset; load offsets while programming.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            fwft   <= fwft_sel;
            prog   <= (ofs_sel_e'(ofs_sel) == OFS_PROG);
            serial <= ser_mode;
            pcnt   <= '0;
            ae_off <= AW'(default_offset(ofs_sel_e'(ofs_sel)));
            af_off <= AW'(default_offset(ofs_sel_e'(ofs_sel)));
        end else if (!cfg_done && prst_n) begin
            if (serial && ser_en) begin
                {ae_off, af_off} <= {ae_off[AW-2:0], af_off, ser_din};
                pcnt             <= pcnt + CW'(1);
            end else if (!serial && wr_en) begin
                if (pcnt == CW'(0)) ae_off <= prog_val;
                else                af_off <= prog_val;
                pcnt <= pcnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/fifo_dc_wr.sv
// Write-side control: binary and Gray write pointer, full flag and
// almost-full flag, all on the write clock.
// Assumes rgray_sync is the read pointer already synchronized to this clock.
module fifo_dc_wr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW-1:0] af_off,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_sync;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign push      = wr_req && !full;
    assign wbin_nx   = wbin + PW'(push);
    assign wgray_nx  = (wbin_nx >> 1) ^ wbin_nx;
    assign rbin_sync = g2b(rgray_sync);
    assign waddr     = wbin[AW-1:0];

    // Advance the write pointer and refresh full and almost-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            full        <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= wgray_nx;
            full        <= (wgray_nx == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
            almost_full <= (PW'(DEPTH) - (wbin_nx - rbin_sync)) <= {1'b0, af_off};
        end
    end
endmodule

// File: rtl/fifo_dc_rd.sv
// Read-side control: read pointer, empty flag, almost-empty flag and the
// output register, which serves both flag styles.
// Assumes wgray_sync is the write pointer already synchronized to this clock.
module fifo_dc_rd #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          fwft_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          fwft,
    output logic [DW-1:0] dout,
    output logic          rd_stat,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic [AW:0] rbin, rbin_nx, rgray_nx, wbin_sync;
    logic        empty, ordy, pop;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign pop       = fwft ? (!empty && (!ordy || rd_en)) : (rd_en && !empty);
    assign rbin_nx   = rbin + PW'(pop);
    assign rgray_nx  = (rbin_nx >> 1) ^ rbin_nx;
    assign wbin_sync = g2b(wgray_sync);
    assign raddr     = rbin[AW-1:0];
    assign rd_stat   = fwft ? ordy : empty;

    // Capture the flag style in this clock domain at master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) fwft <= fwft_sel;
    end

    // Advance the read pointer, refresh flags and load the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin         <= '0;
            rgray        <= '0;
            empty        <= 1'b1;
            almost_empty <= 1'b1;
            ordy         <= 1'b0;
            dout         <= '0;
        end else begin
            rbin         <= rbin_nx;
            rgray        <= rgray_nx;
            empty        <= (rgray_nx == wgray_sync);
            almost_empty <= (wbin_sync - rbin_nx) <= {1'b0, ae_off};
            if (pop) begin
                dout <= rdata;
                ordy <= 1'b1;
            end else if (rd_en) begin
                ordy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fifo_dc_flags.sv
// Top: dual-clock FIFO with selectable flag style and programmable
// threshold flags. Holds the storage array and joins the two domains.
// Assumes DEPTH is a power of two of at least 128 and both resets are held
// low for at least four cycles of the slower clock while both clocks run.
module fifo_dc_flags #(
    parameter int DEPTH = 256,
    parameter int DW    = 36
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic [1:0]    ofs_sel,
    input  logic          ser_mode,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    output logic          wr_stat,
    output logic          almost_full,
    input  logic          rd_en,
    output logic [DW-1:0] dout,
    output logic          rd_stat,
    output logic          almost_empty
);
    localparam int AW = $clog2(DEPTH);

    logic          rst_n;
    logic          fwft_w, fwft_r, cfg_done, push, full;
    logic [AW-1:0] ae_off, af_off, waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_r, rgray_w;
    logic [DW-1:0] rdata;
    logic [DW-1:0] mem [DEPTH];

    assign rst_n   = mrst_n && prst_n;
    assign wr_stat = fwft_w ? !full : full;
    assign rdata   = mem[raddr];

    fifo_dc_cfg #(.AW(AW)) u_cfg (
        .clk      (wclk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .fwft_sel (fwft_sel),
        .ofs_sel  (ofs_sel),
        .ser_mode (ser_mode),
        .wr_en    (wr_en),
        .prog_val (din[AW-1:0]),
        .ser_en   (ser_en),
        .ser_din  (ser_din),
        .fwft     (fwft_w),
        .ae_off   (ae_off),
        .af_off   (af_off),
        .cfg_done (cfg_done)
    );

    fifo_dc_wr #(.AW(AW)) u_wr (
        .clk         (wclk),
        .rst_n       (rst_n),
        .wr_req      (wr_en && cfg_done),
        .rgray_sync  (rgray_w),
        .af_off      (af_off),
        .push        (push),
        .waddr       (waddr),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full)
    );

    fifo_dc_sync2 #(.W(AW + 1)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_w)
    );

    fifo_dc_sync2 #(.W(AW + 1)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_r)
    );

    fifo_dc_rd #(.AW(AW), .DW(DW)) u_rd (
        .clk          (rclk),
        .rst_n        (rst_n),
        .mrst_n       (mrst_n),
        .fwft_sel     (fwft_sel),
        .rd_en        (rd_en),
        .wgray_sync   (wgray_r),
        .ae_off       (ae_off),
        .rdata        (rdata),
        .raddr        (raddr),
        .rgray        (rgray),
        .fwft         (fwft_r),
        .dout         (dout),
        .rd_stat      (rd_stat),
        .almost_empty (almost_empty)
    );

    // Store an accepted word at the write address.
    always_ff @(posedge wclk) begin
        if (push) mem[waddr] <= din;
    end
endmodule

// File: rtl/fifo_dc_flags_chk.sv
// Checker: temporal properties of the dual-clock FIFO, bound to the top.
// Assumes it sees the top's internal pointer, flag and offset signals.
module fifo_dc_flags_chk #(
    parameter int DEPTH = 256,
    parameter int DW    = 36
) (
    input logic                        wclk,
    input logic                        rclk,
    input logic                        mrst_n,
    input logic                        prst_n,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic                        full,
    input logic                        fwft_r,
    input logic                        rd_stat,
    input logic [DW-1:0]               dout,
    input logic [$clog2(DEPTH):0]      wgray,
    input logic [$clog2(DEPTH):0]      rgray,
    input logic [$clog2(DEPTH):0]      wgray_r,
    input logic [$clog2(DEPTH):0]      rgray_w,
    input logic [$clog2(DEPTH)-1:0]    ae_off,
    input logic [$clog2(DEPTH)-1:0]    af_off
);
    localparam int AW = $clog2(DEPTH);

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [AW:0] lvl_w, lvl_r;
    assign lvl_w = g2b(wgray) - g2b(rgray_w);
    assign lvl_r = g2b(wgray_r) - g2b(rgray);

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        lvl_w <= (AW + 1)'(DEPTH)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        lvl_r <= (AW + 1)'(DEPTH)); // R4
    AST_FULL_BLOCKS: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (full && wr_en) |=> $stable(wgray)); // R4
    AST_EMPTY_READ_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (!fwft_r && rd_stat && rd_en) |=> $stable(dout)); // R4
    AST_WPTR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R2
    AST_RPTR_GRAY_STEP: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R2
    AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (fwft_r && rd_stat && !rd_en) |=> (rd_stat && $stable(dout))); // R5
    AST_PRST_KEEPS_OFS: assert property (@(posedge wclk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ae_off) && $stable(af_off))); // R9
endmodule

bind fifo_dc_flags fifo_dc_flags_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full    (full),
    .fwft_r  (fwft_r),
    .rd_stat (rd_stat),
    .dout    (dout),
    .wgray   (wgray),
    .rgray   (rgray),
    .wgray_r (wgray_r),
    .rgray_w (rgray_w),
    .ae_off  (ae_off),
    .af_off  (af_off)
);

// File: tb/fifo_dc_flags_test.sv
// Directed bench for the dual-clock FIFO: one task per scenario, 2:3 clocks.
module fifo_dc_flags_test;
    localparam int CLK_PERIOD = 20;
    localparam int DEPTH      = 256;
    localparam int DW         = 36;
    localparam int AW         = 8;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          fwft_sel = 1'b0, ser_mode = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic [1:0]    ofs_sel = 2'b00;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          wr_stat, rd_stat, almost_full, almost_empty;

    int nchk = 0;
    int nfail = 0;

    fifo_dc_flags #(.DEPTH(DEPTH), .DW(DW)) uut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .ofs_sel(ofs_sel), .ser_mode(ser_mode),
        .ser_en(ser_en), .ser_din(ser_din), .wr_en(wr_en), .din(din),
        .wr_stat(wr_stat), .almost_full(almost_full), .rd_en(rd_en),
        .dout(dout), .rd_stat(rd_stat), .almost_empty(almost_empty)
    );

    initial forever #(CLK_PERIOD / 2) wclk = ~wclk;
    initial begin
        #3;
        forever #(CLK_PERIOD * 3 / 4) rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic mreset(input logic fw, input logic [1:0] sel, input logic ser);
        fwft_sel = fw; ofs_sel = sel; ser_mode = ser;
        mrst_n = 1'b0;
        repeat (5) @(negedge rclk);
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic preset();
        prst_n = 1'b0;
        repeat (5) @(negedge rclk);
        prst_n = 1'b1;
        settle();
    endtask

    task automatic write_words(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en = 1'b1;
            din = DW'(base + i);
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic read_std(input string req, input logic [DW-1:0] exp);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        chk(req, 64'(dout), 64'(exp));
    endtask

    // R1: state after master reset in standard style
    task automatic t_reset_state();
        mreset(1'b0, 2'b00, 1'b0);
        chk("R1 rd_stat", 64'(rd_stat), 64'd1);
        chk("R1 wr_stat", 64'(wr_stat), 64'd0);
        chk("R1 almost_empty", 64'(almost_empty), 64'd1);
        chk("R1 almost_full", 64'(almost_full), 64'd0);
    endtask

    // R3 R4 R6: fill to full with default offset 8, then drain in order
    task automatic t_fill_drain();
        mreset(1'b0, 2'b00, 1'b0);
        write_words(8, 32'h1000); settle();
        chk("R6 ae at 8", 64'(almost_empty), 64'd1);
        chk("R3 not empty", 64'(rd_stat), 64'd0);
        write_words(1, 32'h1008); settle();
        chk("R6 ae at 9", 64'(almost_empty), 64'd0);
        write_words(238, 32'h1009); settle();
        chk("R6 af at 247", 64'(almost_full), 64'd0);
        write_words(1, 32'h1000 + 247); settle();
        chk("R6 af at 248", 64'(almost_full), 64'd1);
        chk("R3 not full at 248", 64'(wr_stat), 64'd0);
        write_words(8, 32'h1000 + 248); settle();
        chk("R3 full", 64'(wr_stat), 64'd1);
        write_words(1, 32'h9999); settle();
        for (int i = 0; i < DEPTH; i++) read_std("R4 R3 drain order", DW'(32'h1000 + i));
        settle();
        chk("R3 empty after drain", 64'(rd_stat), 64'd1);
        read_std("R4 read while empty", DW'(32'h1000 + DEPTH - 1));
    endtask

    // R5 R1 R9: fall-through style and partial reset keeping it
    task automatic t_fwft();
        mreset(1'b1, 2'b00, 1'b0);
        chk("R1 fwft rd_stat", 64'(rd_stat), 64'd0);
        chk("R1 fwft wr_stat", 64'(wr_stat), 64'd1);
        write_words(3, 32'hA0); settle();
        chk("R5 ready", 64'(rd_stat), 64'd1);
        chk("R5 head shown", 64'(dout), 64'hA0);
        for (int i = 1; i < 3; i++) begin
            @(negedge rclk); rd_en = 1'b1;
            @(negedge rclk); rd_en = 1'b0;
            chk("R5 next word", 64'(dout), 64'(32'hA0 + i));
        end
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        chk("R5 drained", 64'(rd_stat), 64'd0);
        write_words(2, 32'hB0); settle();
        preset();
        chk("R9 emptied", 64'(rd_stat), 64'd0);
        chk("R9 style kept", 64'(wr_stat), 64'd1);
        write_words(1, 32'hC5); settle();
        chk("R9 fall-through kept", 64'(dout), 64'hC5);
    endtask

    // R7: parallel programming of offsets
    task automatic t_prog_parallel();
        mreset(1'b0, 2'b11, 1'b0);
        write_words(1, 5);
        write_words(1, 3);
        write_words(5, 32'h500); settle();
        chk("R7 ae at 5", 64'(almost_empty), 64'd1);
        write_words(1, 32'h505); settle();
        chk("R7 ae at 6", 64'(almost_empty), 64'd0);
        read_std("R7 no config word stored", DW'(32'h500));
    endtask

    // R8 R9: serial programming, then partial reset keeps offsets
    task automatic t_prog_serial();
        logic [2*AW-1:0] bits;
        bits = {8'd10, 8'd20};
        mreset(1'b0, 2'b11, 1'b1);
        write_words(1, 32'hDEAD);
        for (int i = 2 * AW - 1; i >= 0; i--) begin
            @(negedge wclk); ser_en = 1'b1; ser_din = bits[i];
        end
        @(negedge wclk); ser_en = 1'b0;
        settle();
        chk("R8 early write ignored", 64'(rd_stat), 64'd1);
        write_words(10, 32'h700); settle();
        chk("R8 ae at 10", 64'(almost_empty), 64'd1);
        write_words(1, 32'h70A); settle();
        chk("R8 ae at 11", 64'(almost_empty), 64'd0);
        write_words(224, 32'h70B); settle();
        chk("R8 af at 235", 64'(almost_full), 64'd0);
        write_words(1, 32'h7EB); settle();
        chk("R8 af at 236", 64'(almost_full), 64'd1);
        preset();
        chk("R9 empty", 64'(rd_stat), 64'd1);
        chk("R9 af cleared", 64'(almost_full), 64'd0);
        write_words(10, 32'h800); settle();
        chk("R9 ae offset kept at 10", 64'(almost_empty), 64'd1);
        write_words(1, 32'h80A); settle();
        chk("R9 ae offset kept at 11", 64'(almost_empty), 64'd0);
    endtask

    // R10 R6: config pins ignored outside master reset; offset 16
    task automatic t_cfg_latch();
        mreset(1'b0, 2'b01, 1'b0);
        fwft_sel = 1'b1; ofs_sel = 2'b00;
        write_words(16, 32'h300); settle();
        chk("R6 ae at 16", 64'(almost_empty), 64'd1);
        write_words(1, 32'h310); settle();
        chk("R10 offset still 16", 64'(almost_empty), 64'd0);
        chk("R10 style still standard", 64'(rd_stat), 64'd0);
        read_std("R10 standard read", DW'(32'h300));
        fwft_sel = 1'b0;
    endtask

    // R2: random enables on both sides, checked against a queue
    task automatic t_random(input logic fw, input int n);
        logic [DW-1:0] q[$];
        mreset(fw, 2'b00, 1'b0);
        fork
            begin
                int sent = 0;
                while (sent < n) begin
                    @(negedge wclk);
                    wr_en = 1'b0;
                    if ((fw ? wr_stat : !wr_stat) && ($urandom % 3 != 0)) begin
                        logic [63:0] tmp;
                        tmp = {$urandom, $urandom};
                        din = tmp[DW-1:0];
                        wr_en = 1'b1;
                        q.push_back(tmp[DW-1:0]);
                        sent++;
                    end
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin
                int got = 0;
                bit pend = 1'b0;
                while (got < n) begin
                    @(negedge rclk);
                    rd_en = 1'b0;
                    if (!fw) begin
                        if (pend) begin
                            chk("R2 std order", 64'(dout), 64'(q.pop_front()));
                            got++;
                            pend = 1'b0;
                        end
                        if (!rd_stat && ($urandom % 2 == 0)) begin
                            rd_en = 1'b1;
                            pend = 1'b1;
                        end
                    end else if (rd_stat && ($urandom % 2 == 0)) begin
                        chk("R2 fwft order", 64'(dout), 64'(q.pop_front()));
                        got++;
                        rd_en = 1'b1;
                    end
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
    endtask

    initial begin
        repeat (190000) @(posedge wclk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fill_drain();
        t_fwft();
        t_prog_parallel();
        t_prog_serial();
        t_cfg_latch();
        t_random(1'b0, 300);
        t_random(1'b1, 300);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule